// File: doc/BRIEF.md
# Single-Port Memory Fetch Arbiter

A stack processor makes two kinds of memory traffic: the execute stage reads and writes data, and the front end fetches instruction words. This block puts both onto one single-port, 16-bit-wide synchronous memory. Each access takes one cycle, and read data comes back on the cycle after the address is presented. A data request always takes the port in the cycle it is raised. Every cycle without a data request is used to fetch instruction words ahead of need into a four-word queue.

The front end can also give a hint of where a jump is likely to go. Once the queue holds at least two words, the block reads the word at that hinted address into a single tagged holding register. When the core then redirects to the hinted address, the held word enters the empty queue in the same cycle, and the jump costs no stall. A redirect to any other address flushes the queue and restarts fetching there. The consumer waits only while the queue is empty.

Top module: `spm_fetch_arb`

## Requirements
- R1: When `dreq_valid` is high, `dreq_ready` is high in the same cycle, and the memory port carries that request: `mem_en`=1, `mem_addr`=`dreq_addr`, `mem_we`=`dreq_we`. No instruction fetch uses the port in that cycle.
- R2: A data read accepted in cycle C raises `drsp_valid` in cycle C+1, with `drsp_data` equal to the memory word at the read address, including any earlier data write.
- R3: A data write drives `mem_we`=1 with `mem_wdata`=`dreq_wdata`, and `drsp_valid` stays low in the following cycle.
- R4: An instruction fetch is issued only in a cycle with no data request and no redirect. Fetched words plus in-flight fetches never exceed 4. With the queue full and no hint pending, the port stays idle (`mem_en`=0).
- R5: `ins_valid` is high exactly when the queue holds a word. Words leave in ascending address order from the last redirect (address 0 after reset), with `ins_word` equal to memory at `ins_addr`. While not taken, the head word holds steady.
- R6: A redirect that misses the held jump word flushes the queue. With the port free, the fetches go out in cycles C+1, C+2 and C+3 at the target, target+1 and target+2. `ins_valid` is low in C+1 and C+2 and high in C+3, with `ins_addr` equal to the target.
- R7: The jump-target fetch is issued only when the queue holds at least 2 words. When it is eligible, it takes the free port ahead of a sequential fetch.
- R8: A redirect whose address equals the tag of a valid held jump word makes `ins_valid` high in the next cycle, with `ins_addr` equal to the redirect address.
- R9: `ins_take` is ignored in a redirect cycle and while the queue is empty.
- R10: During reset, `ins_valid` and `drsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq_valid | input | 1 | Data access request |
| dreq_we | input | 1 | 1 = write, 0 = read |
| dreq_addr | input | 14 | Data word address |
| dreq_wdata | input | 16 | Data write value |
| dreq_ready | output | 1 | Request accepted this cycle |
| drsp_valid | output | 1 | Read data valid |
| drsp_data | output | 16 | Read data |
| ins_valid | output | 1 | Head instruction word present |
| ins_word | output | 16 | Head instruction word |
| ins_addr | output | 14 | Address of head instruction word |
| ins_take | input | 1 | Consumer takes the head word |
| jmp_hint_valid | input | 1 | Jump-target hint strobe |
| jmp_hint_addr | input | 14 | Likely jump target |
| redir_valid | input | 1 | Redirect instruction stream |
| redir_addr | input | 14 | New instruction address |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after address |

## Verification
Two pairs of functions can meet in one cycle. A data request can coincide with a sequential prefetch or a hinted-target fetch that is eligible for the port. A redirect can coincide with a prefetch word returning from memory. The random phase raises data requests, hints, takes and redirects independently each cycle, so these meetings happen often. The bench judges them through the port address and the order and content of delivered words: a fetch that was not suppressed would disturb the word order, and a returning word that was not discarded would do the same. Directed sequences set up the counted cycles of a miss, a hit and a data burst over an empty queue.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_DATA = 2'd1,
        RSP_SEQ  = 2'd2,
        RSP_JMP  = 2'd3
    } rsp_kind_e;
endpackage

// File: rtl/sfa_fifo.sv
module sfa_fifo #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 14,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DATA_W-1:0]            push_word,
    input  logic [ADDR_W-1:0]            push_addr,
    input  logic                         pop,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [DATA_W-1:0]            head_word,
    output logic [ADDR_W-1:0]            head_addr
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] word;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [PW-1:0]                rd;
        logic [PW-1:0]                wr;
        logic [CW-1:0]                cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else if (pop) begin
            st_d.rd  = st_q.rd + 1'b1;
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (push) begin
            st_d.word[st_d.wr] = push_word;
            st_d.addr[st_d.wr] = push_addr;
            st_d.wr            = st_d.wr + 1'b1;
            st_d.cnt           = st_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count     = st_q.cnt;
    assign head_word = st_q.word[st_q.rd];
    assign head_addr = st_q.addr[st_q.rd];
endmodule

// File: rtl/sfa_jtbuf.sv
module sfa_jtbuf #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic [ADDR_W-1:0] load_tag,
    input  logic              clear,
    output logic              held,
    output logic [DATA_W-1:0] word,
    output logic [ADDR_W-1:0] tag
);
    typedef struct packed {
        logic              held;
        logic [DATA_W-1:0] word;
        logic [ADDR_W-1:0] tag;
    } jt_st_t;

    jt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) st_d.held = 1'b0;
        if (load) begin
            st_d.held = 1'b1;
            st_d.word = load_word;
            st_d.tag  = load_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held = st_q.held;
    assign word = st_q.word;
    assign tag  = st_q.tag;
endmodule

// File: rtl/spm_fetch_arb.sv
module spm_fetch_arb
    import sfa_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int JT_MIN_FILL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dreq_valid,
    input  logic              dreq_we,
    input  logic [ADDR_W-1:0] dreq_addr,
    input  logic [DATA_W-1:0] dreq_wdata,
    output logic              dreq_ready,
    output logic              drsp_valid,
    output logic [DATA_W-1:0] drsp_data,
    output logic              ins_valid,
    output logic [DATA_W-1:0] ins_word,
    output logic [ADDR_W-1:0] ins_addr,
    input  logic              ins_take,
    input  logic              jmp_hint_valid,
    input  logic [ADDR_W-1:0] jmp_hint_addr,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int CW = $clog2(FIFO_DEPTH+1);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        rsp_kind_e         rsp_kind;
        logic [ADDR_W-1:0] rsp_addr;
        logic              hint_pend;
        logic [ADDR_W-1:0] hint_addr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [CW-1:0]     q_cnt;
    logic [DATA_W-1:0] q_head_word;
    logic [ADDR_W-1:0] q_head_addr;
    logic              jt_held;
    logic [DATA_W-1:0] jt_word;
    logic [ADDR_W-1:0] jt_tag;

    logic              jt_hit;
    logic              port_free;
    logic              issue_jmp;
    logic              issue_seq;
    logic              q_push;
    logic [DATA_W-1:0] q_push_word;
    logic [ADDR_W-1:0] q_push_addr;
    logic              q_pop;
    logic              jt_load;
    logic [CW:0]       q_committed;

    always_comb begin
        jt_hit      = redir_valid && jt_held && (jt_tag == redir_addr);
        port_free   = !dreq_valid && !redir_valid;
        q_committed = {1'b0, q_cnt} + {{CW{1'b0}}, (st_q.rsp_kind == RSP_SEQ)};
        issue_jmp   = port_free && st_q.hint_pend && (q_cnt >= CW'(JT_MIN_FILL));
        issue_seq   = port_free && !issue_jmp && (q_committed < (CW+1)'(FIFO_DEPTH));

        mem_en    = dreq_valid || issue_jmp || issue_seq;
        mem_we    = dreq_valid && dreq_we;
        mem_wdata = dreq_wdata;
        if (dreq_valid)     mem_addr = dreq_addr;
        else if (issue_jmp) mem_addr = st_q.hint_addr;
        else                mem_addr = st_q.pc;

        q_push      = 1'b0;
        q_push_word = mem_rdata;
        q_push_addr = st_q.rsp_addr;
        if (jt_hit) begin
            q_push      = 1'b1;
            q_push_word = jt_word;
            q_push_addr = jt_tag;
        end else if (!redir_valid && st_q.rsp_kind == RSP_SEQ) begin
            q_push = 1'b1;
        end
        q_pop   = ins_take && (q_cnt != '0) && !redir_valid;
        jt_load = !redir_valid && (st_q.rsp_kind == RSP_JMP);

        st_d = st_q;
        if (dreq_valid)     st_d.rsp_kind = dreq_we ? RSP_NONE : RSP_DATA;
        else if (issue_jmp) st_d.rsp_kind = RSP_JMP;
        else if (issue_seq) st_d.rsp_kind = RSP_SEQ;
        else                st_d.rsp_kind = RSP_NONE;
        st_d.rsp_addr = mem_addr;

        if (redir_valid)    st_d.pc = jt_hit ? redir_addr + ADDR_W'(1) : redir_addr;
        else if (issue_seq) st_d.pc = st_q.pc + ADDR_W'(1);

        if (redir_valid || issue_jmp) st_d.hint_pend = 1'b0;
        if (jmp_hint_valid) begin
            st_d.hint_pend = 1'b1;
            st_d.hint_addr = jmp_hint_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.rsp_kind <= RSP_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    sfa_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (redir_valid),
        .push      (q_push),
        .push_word (q_push_word),
        .push_addr (q_push_addr),
        .pop       (q_pop),
        .count     (q_cnt),
        .head_word (q_head_word),
        .head_addr (q_head_addr)
    );

    sfa_jtbuf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_jt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (jt_load),
        .load_word (mem_rdata),
        .load_tag  (st_q.rsp_addr),
        .clear     (jt_hit),
        .held      (jt_held),
        .word      (jt_word),
        .tag       (jt_tag)
    );

    assign dreq_ready = dreq_valid;
    assign drsp_valid = (st_q.rsp_kind == RSP_DATA);
    assign drsp_data  = mem_rdata;
    assign ins_valid  = (q_cnt != '0);
    assign ins_word   = q_head_word;
    assign ins_addr   = q_head_addr;
endmodule

module spm_fetch_arb_chk #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dreq_valid,
    input logic              dreq_we,
    input logic [ADDR_W-1:0] dreq_addr,
    input logic              dreq_ready,
    input logic              drsp_valid,
    input logic              ins_valid,
    input logic [DATA_W-1:0] ins_word,
    input logic [ADDR_W-1:0] ins_addr,
    input logic              ins_take,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_addr,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              jt_hit
);
    // R1
    data_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_valid |-> (dreq_ready && mem_en && mem_addr == dreq_addr && mem_we == dreq_we));

    // R2
    rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_valid && !dreq_we) |=> drsp_valid);

    // R3
    wr_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_valid && dreq_we) |=> !drsp_valid);

    // R4
    redir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && !dreq_valid) |-> !mem_en);

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_take && !redir_valid) |=>
            (ins_valid && $stable(ins_addr) && $stable(ins_word)));

    // R6
    miss_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && !jt_hit) |=> !ins_valid);

    // R8
    hit_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jt_hit |=> (ins_valid && ins_addr == $past(redir_addr)));
endmodule

bind spm_fetch_arb spm_fetch_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/spm_fetch_arb_tb.sv
module spm_fetch_arb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dreq_valid = 1'b0, dreq_we = 1'b0;
    logic [13:0] dreq_addr = '0;
    logic [15:0] dreq_wdata = '0;
    logic        dreq_ready, drsp_valid;
    logic [15:0] drsp_data;
    logic        ins_valid;
    logic [15:0] ins_word;
    logic [13:0] ins_addr;
    logic        ins_take = 1'b0;
    logic        jmp_hint_valid = 1'b0;
    logic [13:0] jmp_hint_addr = '0;
    logic        redir_valid = 1'b0;
    logic [13:0] redir_addr = '0;
    logic        mem_en, mem_we;
    logic [13:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spm_fetch_arb u_dut (.*);

    function automatic logic [15:0] code_word(input logic [13:0] a);
        return (16'(a) * 16'd37) ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] data_init(input int i);
        return 16'hD000 + 16'(i);
    endfunction

    // memory model: code below 0x2000 is fixed, data window at 0x2000 has 64 words
    logic [15:0] dmem_m [64];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) dmem_m[i] <= data_init(i);
        end else if (mem_en) begin
            if (mem_we) begin
                if (mem_addr[13]) dmem_m[mem_addr[5:0]] <= mem_wdata;
            end else begin
                mem_rdata <= mem_addr[13] ? dmem_m[mem_addr[5:0]] : code_word(mem_addr);
            end
        end
    end

    logic [15:0] exp_dmem [64];
    logic [13:0] exp_pc = '0;
    bit          pend_rd = 1'b0;
    logic [15:0] pend_val = '0;
    logic [13:0] last_hint = 14'h0100;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit dv, input bit dwe, input logic [13:0] da, input logic [15:0] dw,
                       input bit tk, input bit rv, input logic [13:0] ra,
                       input bit hv, input logic [13:0] ha);
        dreq_valid = dv; dreq_we = dwe; dreq_addr = da; dreq_wdata = dw;
        ins_take = tk; redir_valid = rv; redir_addr = ra;
        jmp_hint_valid = hv; jmp_hint_addr = ha;
        #1;
        if (dv) chk(dreq_ready && mem_en && mem_addr == da && mem_we == dwe, "R1 port",
                    {17'(mem_en), mem_addr}, {17'(1), da});
        if (pend_rd) chk(drsp_valid && drsp_data == pend_val, "R2 read data",
                         {15'(drsp_valid), drsp_data}, {15'(1), pend_val});
        else         chk(!drsp_valid, "R3 no response", 32'(drsp_valid), 32'(0));
        if (ins_valid && tk && !rv) begin
            chk(ins_addr == exp_pc && ins_word == code_word(exp_pc), "R5 order",
                {ins_addr, ins_word}, {exp_pc, code_word(exp_pc)});
            exp_pc = exp_pc + 14'd1;
        end
        if (rv) exp_pc = ra;
        pend_rd  = dv && !dwe;
        pend_val = exp_dmem[da[5:0]];
        if (dv && dwe) exp_dmem[da[5:0]] = dw;
        @(posedge clk);
        @(negedge clk);
        dreq_valid = 1'b0; dreq_we = 1'b0; ins_take = 1'b0;
        redir_valid = 1'b0; jmp_hint_valid = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, '0, 0, 0, '0, 0, '0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) exp_dmem[i] = data_init(i);
        repeat (3) @(negedge clk);
        #1;
        // R10
        chk(!ins_valid && !drsp_valid, "R10 reset", {ins_valid, drsp_valid}, 32'(0));
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R4 / R5: queue fills from 0, then the port goes quiet
        idle(20);
        chk(!mem_en, "R4 idle when full", 32'(mem_en), 32'(0));
        chk(ins_valid && ins_addr == 14'd0 && ins_word == code_word(14'd0), "R5 head after reset",
            {ins_addr, ins_word}, {14'd0, code_word(14'd0)});

        // R8: hinted target already held, redirect hits
        cyc(0, 0, '0, '0, 0, 0, '0, 1, 14'h0100);
        idle(4);
        redir_valid = 1'b1; redir_addr = 14'h0100; #1;
        chk(!mem_en, "R4 no fetch on redirect", 32'(mem_en), 32'(0));
        cyc(0, 0, '0, '0, 0, 1, 14'h0100, 0, '0);
        chk(ins_valid && ins_addr == 14'h0100 && ins_word == code_word(14'h0100), "R8 hit no stall",
            {ins_valid, ins_addr}, {1'b1, 14'h0100});

        // R6 / R7: miss with a hint given at the same time
        cyc(0, 0, '0, '0, 0, 1, 14'h0300, 1, 14'h0500);
        chk(mem_en && mem_addr == 14'h0300, "R6 first fetch", 32'(mem_addr), 32'h300);
        chk(!ins_valid, "R6 empty C+1", 32'(ins_valid), 32'(0));
        idle(1);
        chk(mem_en && mem_addr == 14'h0301, "R7 no jump fetch yet", 32'(mem_addr), 32'h301);
        chk(!ins_valid, "R6 empty C+2", 32'(ins_valid), 32'(0));
        idle(1);
        chk(mem_en && mem_addr == 14'h0302, "R7 no jump fetch with one word", 32'(mem_addr), 32'h302);
        chk(ins_valid && ins_addr == 14'h0300, "R6 first word C+3", {ins_valid, ins_addr}, {1'b1, 14'h0300});
        idle(1);
        chk(mem_en && mem_addr == 14'h0500, "R7 jump fetch at two words", 32'(mem_addr), 32'h500);

        // R1: data burst over an empty queue starves fetch
        cyc(0, 0, '0, '0, 0, 1, 14'h0700, 0, '0);
        for (int k = 0; k < 6; k++) begin
            cyc(1, 0, 14'h2000 | 14'(k), '0, 1, 0, '0, 0, '0);
            chk(!ins_valid, "R1 fetch starved", 32'(ins_valid), 32'(0));
        end
        idle(1);

        // R9: take during redirect and while empty is ignored
        cyc(0, 0, '0, '0, 1, 1, 14'h0900, 0, '0);
        cyc(0, 0, '0, '0, 1, 0, '0, 0, '0);
        cyc(0, 0, '0, '0, 1, 0, '0, 0, '0);
        chk(ins_valid && ins_addr == 14'h0900, "R9 take ignored", {ins_valid, ins_addr}, {1'b1, 14'h0900});

        // random mix
        void'($urandom(32'd2718));
        for (int n = 0; n < 3000; n++) begin
            bit dv, dwe, tk, rv, hv;
            logic [13:0] da, ra, ha;
            logic [15:0] dw;
            dv  = ($urandom % 100) < 30;
            dwe = ($urandom % 100) < 40;
            da  = 14'h2000 | 14'($urandom % 64);
            dw  = 16'($urandom);
            tk  = ($urandom % 100) < 60;
            hv  = ($urandom % 100) < 5;
            ha  = 14'($urandom % 14'h1F00);
            rv  = (n == 0) || (($urandom % 100) < 3);
            ra  = (($urandom % 2) == 0) ? last_hint : 14'($urandom % 14'h1F00);
            if (hv) last_hint = ha;
            cyc(dv, dwe, da, dw, tk, rv, ra, hv, ha);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule